// File: doc/BRIEF.md
# Performance Event Counter Bank

This block is the counting core of a per-core performance monitor. It holds one free-running 32-bit cycle counter and a parameterised set of 32-bit event counters (up to 31). Each event counter has an 8-bit selector that picks one line out of a 256-wide event vector. A counter advances on a cycle where its selected line is high, its own enable bit is set and the global enable is on. Software reaches the block over a simple single-cycle register bus. Writes take effect at the next clock edge. Read data is combinational from the address.

Event counters have no address of their own. Software first writes a counter index into the select register. The count window and the selector window then act on that counter. The enable mask is changed through two write-one registers, one that sets bits and one that clears them. The control register starts global counting, resets the event counters or the cycle counter as one-shot actions, and can slow the cycle counter to one step per 64 clocks. When any counter wraps, it raises a one-cycle pulse on its bit of the overflow vector. A separate flag and interrupt block consumes that vector.

The block has no multi-state sequencer. Its behaviour is held in a few registers: global enable, divide mode, enable mask, select index, selectors and counts. The prescaler for the divided cycle mode is a 6-bit phase that wraps every 64 enabled clocks.

Top module: `pmc_bank`

## Requirements
- R1: While control bit 0 (global enable) is clear, no counter advances, whatever the enable mask holds.
- R2: Writing control with bit 1 set clears every event counter to zero in that edge. Bit 1 is not stored and reads back 0.
- R3: Writing control with bit 2 set clears only the cycle counter and its divide phase. Event counters keep their values. Bit 2 reads back 0.
- R4: With control bit 3 set, the enabled cycle counter advances once per 64 enabled clocks, on the 64th, 128th, … such clock.
- R5: Control reads back stored bits 0, 3, 4 and 5 in place, bits 1 and 2 as 0, and the number of event counters in bits 15:11. All other bits read 0, and writes to bits above 5 are dropped.
- R6: In the enable-set (address 1) and enable-clear (address 2) registers, bit 31 is the cycle counter and bit i is event counter i. A 1 in the set register enables that counter, a 1 in the clear register disables it, and zeros change nothing. Reading either address returns the current mask.
- R7: The select register (address 3) holds a 5-bit index. The count window (address 5) reads and writes the value of the event counter so named, and the selector window (address 6) reads and writes its 8-bit selector.
- R8: An enabled event counter adds one on each enabled clock whose event line, indexed by its selector, is high. It does not move when that line is low.
- R9: A counter stepping from 0xFFFFFFFF to 0 drives a one-cycle pulse on the overflow vector, in the same cycle the new zero count appears. Bit 31 belongs to the cycle counter and bit i to event counter i.
- R10: A select index at or above the number of event counters makes both windows read 0 and ignore writes.
- R11: After reset, control reads only the counter-number field, the enable mask is 0, and all counts, selectors and overflow bits are 0.
- R12: Software may write the cycle counter directly at address 4 and read it back there. A bus write to a counter wins over a reset action and over an increment in the same cycle.
- R13: Word addresses are 0 control, 1 enable set, 2 enable clear, 3 select, 4 cycle count, 5 count window, 6 selector window. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_in | input | 256 | Event lines, one per selector code |
| ovf_pulse | output | 32 | Wrap pulses: bit 31 cycle counter, bit i event counter i |

## Verification
The bound checker watches several behaviours on every cycle:
- The cycle count stays frozen while the global enable is off and the bus is quiet.
- The cycle reset leaves a zero count one edge later.
- Set and clear writes to the cycle-counter enable bit take effect on the next edge.
- Every cycle overflow pulse coincides with a zero count and is never followed by a second pulse.
- The counter-number field and the unused address read correctly.

Other behaviours need the bench's scenarios: exact counts after a known number of enabled clocks, divide-by-64 stepping, event selection through the windows, reset-action isolation between the two counter kinds, and the behaviour of out-of-range select indices.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;

    localparam int CNT_W  = 32;
    localparam int SEL_W  = 5;
    localparam int EVSEL_W = 8;
    localparam int PRESC_W = 6;

    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_ENSET  = 3'd1,
        RA_ENCLR  = 3'd2,
        RA_SEL    = 3'd3,
        RA_CYC    = 3'd4,
        RA_CNTWIN = 3'd5,
        RA_SELWIN = 3'd6,
        RA_HOLE   = 3'd7
    } reg_addr_e;

    localparam int CB_GLOBAL = 0;
    localparam int CB_EVRST  = 1;
    localparam int CB_CYRST  = 2;
    localparam int CB_DIV    = 3;
    localparam int CYC_BIT   = 31;

endpackage

// File: rtl/pmc_regs.sv
`timescale 1ns/1ps
module pmc_regs
    import pmc_pkg::*;
#(
    parameter int NUM_EVT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_addr_e         wr_addr,
    input  logic [31:0]       wr_data,
    output logic              glob_en,
    output logic              div_mode,
    output logic              evt_rst,
    output logic              cyc_rst,
    output logic [31:0]       en_mask,
    output logic [SEL_W-1:0]  sel_idx,
    output logic [31:0]       ctrl_rd
);

    localparam logic [31:0] IMPL_MASK = (32'h1 << CYC_BIT) | ((32'h1 << NUM_EVT) - 32'h1);
    localparam logic [4:0]  NUM_FIELD = 5'(NUM_EVT);

    logic [3:0] ctrl_q;   // {bit5, bit4, div, global}
    logic       wr_ctrl;

    assign wr_ctrl  = wr_en && (wr_addr == RA_CTRL);
    assign evt_rst  = wr_ctrl && wr_data[CB_EVRST];
    assign cyc_rst  = wr_ctrl && wr_data[CB_CYRST];
    assign glob_en  = ctrl_q[0];
    assign div_mode = ctrl_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            en_mask <= '0;
            sel_idx <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                RA_CTRL:  ctrl_q  <= {wr_data[5], wr_data[4], wr_data[CB_DIV], wr_data[CB_GLOBAL]};
                RA_ENSET: en_mask <= en_mask | (wr_data & IMPL_MASK);
                RA_ENCLR: en_mask <= en_mask & ~(wr_data & IMPL_MASK);
                RA_SEL:   sel_idx <= wr_data[SEL_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        ctrl_rd        = '0;
        ctrl_rd[15:11] = NUM_FIELD;
        ctrl_rd[0]     = ctrl_q[0];
        ctrl_rd[3]     = ctrl_q[1];
        ctrl_rd[4]     = ctrl_q[2];
        ctrl_rd[5]     = ctrl_q[3];
    end

endmodule

// File: rtl/pmc_cycle_ctr.sv
`timescale 1ns/1ps
module pmc_cycle_ctr
    import pmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             div_mode,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    logic [PRESC_W-1:0] phase;
    logic               tick;

    assign tick = run && (!div_mode || (phase == {PRESC_W{1'b1}}));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (clr) begin
            phase <= '0;
        end else if (run && div_mode) begin
            phase <= phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (load) begin
                count <= load_val;
            end else if (clr) begin
                count <= '0;
            end else if (tick) begin
                count <= count + 1'b1;
                ovf   <= (count == {CNT_W{1'b1}});
            end
        end
    end

endmodule

// File: rtl/pmc_event_ctr.sv
`timescale 1ns/1ps
module pmc_event_ctr
    import pmc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic [(1<<EVSEL_W)-1:0] evt_vec,
    input  logic                  clr,
    input  logic                  cnt_load,
    input  logic                  sel_load,
    input  logic [CNT_W-1:0]      wr_data,
    output logic [CNT_W-1:0]      count,
    output logic [EVSEL_W-1:0]    evsel,
    output logic                  ovf
);

    logic hit;

    assign hit = run && evt_vec[evsel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evsel <= '0;
        end else if (sel_load) begin
            evsel <= wr_data[EVSEL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (cnt_load) begin
                count <= wr_data;
            end else if (clr) begin
                count <= '0;
            end else if (hit) begin
                count <= count + 1'b1;
                ovf   <= (count == {CNT_W{1'b1}});
            end
        end
    end

endmodule

// File: rtl/pmc_bank.sv
`timescale 1ns/1ps
module pmc_bank
    import pmc_pkg::*;
#(
    parameter int NUM_EVT = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [2:0]              bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic [(1<<EVSEL_W)-1:0] evt_in,
    output logic [31:0]             ovf_pulse
);

    localparam int SLOTS = 1 << SEL_W;

    reg_addr_e          addr_e;
    logic               glob_en;
    logic               div_mode;
    logic               evt_rst;
    logic               cyc_rst;
    logic [31:0]        en_mask;
    logic [SEL_W-1:0]   sel_idx;
    logic [31:0]        ctrl_rd;
    logic [CNT_W-1:0]   cyc_cnt;
    logic               cyc_ovf;
    logic [CNT_W-1:0]   cnt_arr [SLOTS];
    logic [EVSEL_W-1:0] sel_arr [SLOTS];
    logic [30:0]        ovf_evt;

    assign addr_e = reg_addr_e'(bus_addr);

    pmc_regs #(.NUM_EVT(NUM_EVT)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .wr_addr  (addr_e),
        .wr_data  (bus_wdata),
        .glob_en  (glob_en),
        .div_mode (div_mode),
        .evt_rst  (evt_rst),
        .cyc_rst  (cyc_rst),
        .en_mask  (en_mask),
        .sel_idx  (sel_idx),
        .ctrl_rd  (ctrl_rd)
    );

    pmc_cycle_ctr cyc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (glob_en && en_mask[CYC_BIT]),
        .div_mode (div_mode),
        .clr      (cyc_rst),
        .load     (bus_wr && (addr_e == RA_CYC)),
        .load_val (bus_wdata),
        .count    (cyc_cnt),
        .ovf      (cyc_ovf)
    );

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i < NUM_EVT) begin : g_ctr
            pmc_event_ctr ctr_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .run      (glob_en && en_mask[i]),
                .evt_vec  (evt_in),
                .clr      (evt_rst),
                .cnt_load (bus_wr && (addr_e == RA_CNTWIN) && (sel_idx == SEL_W'(i))),
                .sel_load (bus_wr && (addr_e == RA_SELWIN) && (sel_idx == SEL_W'(i))),
                .wr_data  (bus_wdata),
                .count    (cnt_arr[i]),
                .evsel    (sel_arr[i]),
                .ovf      (ovf_evt[i])
            );
        end else begin : g_empty
            assign cnt_arr[i] = '0;
            assign sel_arr[i] = '0;
            if (i < 31) begin : g_noovf
                assign ovf_evt[i] = 1'b0;
            end
        end
    end

    assign ovf_pulse = {cyc_ovf, ovf_evt};

    always_comb begin
        unique case (addr_e)
            RA_CTRL:   bus_rdata = ctrl_rd;
            RA_ENSET:  bus_rdata = en_mask;
            RA_ENCLR:  bus_rdata = en_mask;
            RA_SEL:    bus_rdata = {{(32-SEL_W){1'b0}}, sel_idx};
            RA_CYC:    bus_rdata = cyc_cnt;
            RA_CNTWIN: bus_rdata = cnt_arr[sel_idx];
            RA_SELWIN: bus_rdata = {{(32-EVSEL_W){1'b0}}, sel_arr[sel_idx]};
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pmc_bank_chk.sv
`timescale 1ns/1ps
module pmc_bank_chk #(
    parameter int NUM_EVT = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [2:0]  bus_addr,
    input logic        wd_cyc_rst,
    input logic        wd_cyc_bit,
    input logic [31:0] bus_rdata,
    input logic        cyc_ovf,
    input logic        glob_en,
    input logic        cyc_en,
    input logic [31:0] cyc_cnt
);

    localparam logic [4:0] NUM_FIELD = 5'(NUM_EVT);

    a_r1_cyc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !bus_wr) |=> $stable(cyc_cnt));

    a_r3_cyc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && wd_cyc_rst) |=> (cyc_cnt == 32'd0));

    a_r6_set_cyc: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd1 && wd_cyc_bit) |=> cyc_en);

    a_r6_clr_cyc: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd2 && wd_cyc_bit) |=> !cyc_en);

    a_r9_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_ovf |-> (cyc_cnt == 32'd0));

    a_r9_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_ovf |=> !cyc_ovf);

    a_r5_num_field: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd0) |-> (bus_rdata[15:11] == NUM_FIELD));

    a_r13_hole: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd7) |-> (bus_rdata == 32'd0));

endmodule

bind pmc_bank pmc_bank_chk #(.NUM_EVT(NUM_EVT)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .wd_cyc_rst (bus_wdata[2]),
    .wd_cyc_bit (bus_wdata[31]),
    .bus_rdata  (bus_rdata),
    .cyc_ovf    (ovf_pulse[31]),
    .glob_en    (glob_en),
    .cyc_en     (en_mask[31]),
    .cyc_cnt    (cyc_cnt)
);

// File: tb/pmc_bank_tb.sv
`timescale 1ns/1ps
module pmc_bank_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [255:0] evt_in = '0;
    logic [31:0]  ovf_pulse;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    typedef struct {
        bit          is_ovf;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #2.5 clk = ~clk;

    pmc_bank #(.NUM_EVT(4)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_in    (evt_in),
        .ovf_pulse (ovf_pulse)
    );

    // monitor: compares queued expectations 2 ns after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_ovf ? ovf_pulse : bus_rdata;
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.is_ovf = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic chk_ovf(input logic [31:0] e, input string tag);
        item_t it;
        it.is_ovf = 1'b1; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R13 actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        rd(3'd0, 32'h0000_2000, "R11 ctrl after reset");
        rd(3'd1, 32'h0, "R11 enable mask after reset");
        rd(3'd4, 32'h0, "R11 cycle count after reset");
        rd(3'd5, 32'h0, "R11 counter0 after reset");
        rd(3'd6, 32'h0, "R11 selector0 after reset");
        chk_ovf(32'h0, "R11 overflow after reset");

        // R5 control read-back, R13 hole
        wr(3'd0, 32'h0000_003F);
        rd(3'd0, 32'h0000_2039, "R5 ctrl stored bits");
        wr(3'd0, 32'hFFFF_FFC0);
        rd(3'd0, 32'h0000_2000, "R5 ctrl upper bits dropped");
        rd(3'd7, 32'h0, "R13 unused address");

        // R7 selector windows
        wr(3'd3, 32'd0); wr(3'd6, 32'd5);
        wr(3'd3, 32'd1); wr(3'd6, 32'd9);
        rd(3'd6, 32'd9, "R7 selector of counter1");
        rd(3'd3, 32'd1, "R7 select readback");
        wr(3'd3, 32'd0);
        rd(3'd6, 32'd5, "R7 selector of counter0");

        // R6 enables
        wr(3'd1, 32'h8000_0003);
        rd(3'd1, 32'h8000_0003, "R6 set read at set addr");
        rd(3'd2, 32'h8000_0003, "R6 set read at clear addr");

        // R8 counting: 10 enabled edges
        evt_in[5] = 1'b1;
        wr(3'd0, 32'h1);
        repeat (9) @(negedge clk);
        wr(3'd0, 32'h0);
        rd(3'd4, 32'd10, "R8 cycle count over 10 clocks");
        rd(3'd5, 32'd10, "R8 counter0 with high event");
        wr(3'd3, 32'd1);
        rd(3'd5, 32'd0, "R8 counter1 with low event");

        // R6 clear and zero writes
        wr(3'd2, 32'h1);
        rd(3'd1, 32'h8000_0002, "R6 clear bit0");
        wr(3'd2, 32'h0);
        rd(3'd2, 32'h8000_0002, "R6 zero clear no effect");
        wr(3'd1, 32'h0);
        rd(3'd1, 32'h8000_0002, "R6 zero set no effect");

        // R2 event reset
        wr(3'd0, 32'h2);
        rd(3'd0, 32'h0000_2000, "R2 bit1 self clearing");
        wr(3'd3, 32'd0);
        rd(3'd5, 32'd0, "R2 counter0 cleared");
        rd(3'd4, 32'd10, "R2 cycle counter kept");

        // R3 cycle reset
        wr(3'd5, 32'h55);
        wr(3'd0, 32'h4);
        rd(3'd4, 32'd0, "R3 cycle counter cleared");
        rd(3'd5, 32'h55, "R3 counter0 kept");
        rd(3'd0, 32'h0000_2000, "R3 bit2 self clearing");

        // R10 out-of-range select
        wr(3'd3, 32'd7);
        rd(3'd5, 32'd0, "R10 count window out of range");
        rd(3'd6, 32'd0, "R10 selector window out of range");
        wr(3'd5, 32'h1234);
        wr(3'd6, 32'h77);
        wr(3'd3, 32'd0);
        rd(3'd5, 32'h55, "R10 counter0 untouched");
        rd(3'd6, 32'd5, "R10 selector0 untouched");
        wr(3'd3, 32'd3);
        rd(3'd5, 32'd0, "R10 counter3 untouched");
        rd(3'd6, 32'd0, "R10 selector3 untouched");

        // R12 direct cycle write
        wr(3'd4, 32'h1234_5678);
        rd(3'd4, 32'h1234_5678, "R12 cycle write readback");

        // R9 overflow
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd3, 32'd0);
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd1, 32'h1);
        wr(3'd0, 32'h1);
        chk_ovf(32'h0, "R9 no pulse before wrap");
        chk_ovf(32'h8000_0001, "R9 wrap pulse cycle and counter0");
        chk_ovf(32'h0, "R9 pulse lasts one cycle");
        wr(3'd0, 32'h0);
        rd(3'd4, 32'd3, "R9 cycle count after wrap");
        rd(3'd5, 32'd3, "R9 counter0 after wrap");
        repeat (5) @(negedge clk);
        rd(3'd4, 32'd3, "R1 cycle frozen while global off");
        rd(3'd5, 32'd3, "R1 counter0 frozen while global off");

        // R4 divide by 64 over 130 enabled clocks
        wr(3'd0, 32'h4);
        wr(3'd0, 32'h9);
        repeat (129) @(negedge clk);
        wr(3'd0, 32'h0);
        rd(3'd4, 32'd2, "R4 divided cycle count");
        rd(3'd5, 32'd133, "R4 counter0 undivided");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule